// File: doc/BRIEF.md
# Permutation-Coded LUT Truth Table Expander

This block runs while a device is being configured. The bitstream stores a shortened truth table for each look-up table. For a K-input LUT, floor(log2 K!) bits of that table are left out of the stream. The missing bits are recovered from the order in which the input multiplexers present the K chosen signals.

For each LUT, the block takes two things through a valid/ready handshake: the stored bits and the K select values. It turns the relative order of the select values into a permutation rank. The low bits of that rank become the top of the truth table. The stored bits fill the remaining lower positions, and the full 2^K-bit table is handed to a LUT write port. The LUT storage keeps its full width; only the stream is shorter.

A single instance serves every LUT on the device, one LUT in flight at a time. No logic timing path passes through it.

Top module: `lut_regen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A LUT is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 from the following cycle onwards.
- R3: Bits [STORED_W-1:0] of `out_table` equal `in_bits` of the accepted transfer, bit for bit. STORED_W is 2^K - NE, where NE = floor(log2 K!). For K=4 this gives NE=4 and STORED_W=12.
- R4: Bits [2^K-1:STORED_W] of `out_table` hold the permutation code of the accepted selects.
  - Lane i is `in_sel[i*SEL_W +: SEL_W]`, and lane 0 is the first position.
  - Digit d_i counts the lanes j>i whose value is strictly smaller than lane i.
  - The rank is the sum of d_i·(K-1-i)!, and the code is that rank modulo 2^NE.
  - Ascending selects give code 0. For K=4, descending selects give rank 23, so code 7.
- R5: While `out_valid` is 1, `in_ready` is 0. Any `in_valid` pulse in that time leaves `out_table` unchanged.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_table` stays stable.
- R7: After a rising edge with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.
- R8: Equal select values count as no inversion. With all lanes equal, the code is 0.
- R9: For K=4, the 24 orderings of distinct selects produce all 16 codes. Any 16-bit table, sent as its low 12 bits with an ordering whose code equals its top 4 bits, comes back identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stored bits and selects are present |
| in_ready | output | 1 | Block can take a LUT |
| in_bits | input | STORED_W | Stored truth-table bits, lowest position in bit 0 |
| in_sel | input | K*SEL_W | Input-mux select values, lane i at [i*SEL_W +: SEL_W] |
| out_valid | output | 1 | Full table is present |
| out_ready | input | 1 | Write port takes the table |
| out_table | output | 2^K | Full truth table |

## Verification
A wrong inversion count or rank weight corrupts only the top NE bits of `out_table`. It shows one cycle after acceptance, for the select orderings that exercise that lane. Only a sweep over every ordering exposes every such fault. A slip in the handshake state shows in the same window in one of two ways: a table that changes while held, or an `in_ready` that returns while a result is still pending. The round-trip check ties the recovered code straight back to a source table.

// File: rtl/lut_regen_pkg.sv
package lut_regen_pkg;

  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  function automatic int flog2(input int n);
    int r;
    int v;
    r = 0;
    v = n;
    while (v > 1) begin
      v = v / 2;
      r = r + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/lut_lehmer.sv
module lut_lehmer #(
  parameter int K     = 4,
  parameter int SEL_W = 3,
  parameter int LD_W  = $clog2(K)
) (
  input  logic [K*SEL_W-1:0] sel,
  output logic [K*LD_W-1:0]  digits
);

  for (genvar i = 0; i < K; i++) begin : g_lane
    logic [LD_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = i + 1; j < K; j++)
        if (sel[j*SEL_W +: SEL_W] < sel[i*SEL_W +: SEL_W]) cnt = cnt + 1'b1;
    end
    assign digits[i*LD_W +: LD_W] = cnt;
  end

endmodule

// File: rtl/lut_rank.sv
module lut_rank #(
  parameter int K      = 4,
  parameter int LD_W   = $clog2(K),
  parameter int RANK_W = 5,
  parameter int NE     = 4
) (
  input  logic [K*LD_W-1:0] digits,
  output logic [NE-1:0]     code
);

  logic [RANK_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < K; i++)
      acc = acc * RANK_W'(K - i) + RANK_W'(digits[i*LD_W +: LD_W]);
  end

  assign code = acc[NE-1:0];

endmodule

// File: rtl/lut_regen.sv
module lut_regen
  import lut_regen_pkg::*;
#(
  parameter int K     = 4,
  parameter int SEL_W = 3,
  localparam int FULL_W   = 1 << K,
  localparam int NE       = flog2(fact(K)),
  localparam int STORED_W = FULL_W - NE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [STORED_W-1:0]  in_bits,
  input  logic [K*SEL_W-1:0]   in_sel,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [FULL_W-1:0]    out_table
);

  localparam int LD_W   = $clog2(K);
  localparam int RANK_W = (fact(K) > 1) ? $clog2(fact(K)) : 1;

  logic [K*LD_W-1:0] digits;
  logic [NE-1:0]     code;
  logic              accept;

  lut_lehmer #(.K(K), .SEL_W(SEL_W), .LD_W(LD_W)) u_lehmer (
    .sel    (in_sel),
    .digits (digits)
  );

  lut_rank #(.K(K), .LD_W(LD_W), .RANK_W(RANK_W), .NE(NE)) u_rank (
    .digits (digits),
    .code   (code)
  );

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_table <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_table <= {code, in_bits};
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lut_regen_chk.sv
module lut_regen_chk #(
  parameter int FULL_W   = 16,
  parameter int STORED_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [STORED_W-1:0] in_bits,
  input logic                out_valid,
  input logic                out_ready,
  input logic [FULL_W-1:0]   out_table
);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_table[STORED_W-1:0] == $past(in_bits));

  // R5
  no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_table));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid);

endmodule

bind lut_regen lut_regen_chk #(.FULL_W(FULL_W), .STORED_W(STORED_W)) u_chk (.*);

// File: tb/lut_regen_test.sv
`timescale 1ns/1ps
module lut_regen_test;

  localparam int K      = 4;
  localparam int SEL_W  = 3;
  localparam int FULL   = 16;
  localparam int NE     = 4;
  localparam int STORED = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [STORED-1:0] in_bits = '0;
  logic [K*SEL_W-1:0] in_sel = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [FULL-1:0]   out_table;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lut_regen #(.K(K), .SEL_W(SEL_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_sel(in_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_table(out_table)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int fct(input int n);
    int r = 1;
    for (int i = 2; i <= n; i++) r *= i;
    return r;
  endfunction

  // Reference code: weighted inversion counts, reduced to NE bits
  function automatic logic [NE-1:0] ref_code(input logic [K*SEL_W-1:0] s);
    int total = 0;
    for (int i = 0; i < K; i++) begin
      int d = 0;
      for (int j = i + 1; j < K; j++)
        if (s[j*SEL_W +: SEL_W] < s[i*SEL_W +: SEL_W]) d++;
      total += d * fct(K - 1 - i);
    end
    return NE'(total % (1 << NE));
  endfunction

  function automatic logic [K*SEL_W-1:0] pack(input int l0, input int l1, input int l2, input int l3);
    return {SEL_W'(l3), SEL_W'(l2), SEL_W'(l1), SEL_W'(l0)};
  endfunction

  task automatic send(input logic [STORED-1:0] b, input logic [K*SEL_W-1:0] s);
    @(negedge clk);
    in_bits = b; in_sel = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic one(input string req, input logic [STORED-1:0] b, input logic [K*SEL_W-1:0] s,
                     input logic [NE-1:0] exp_code);
    send(b, s);
    chk("R2 out_valid after accept", out_valid, 1);
    chk("R3 stored bits", out_table[STORED-1:0], b);
    chk(req, out_table[FULL-1:STORED], exp_code);
    release_out();
    chk("R7 out_valid after release", out_valid, 0);
    chk("R7 in_ready after release", in_ready, 1);
  endtask

  task automatic t_orders();
    one("R4 ascending", 12'hA5C, pack(0, 1, 2, 3), 4'd0);
    one("R4 descending", 12'h3F0, pack(3, 2, 1, 0), 4'd7);
    one("R4 mixed 1", 12'h001, pack(6, 0, 4, 2), ref_code(pack(6, 0, 4, 2)));
    one("R4 mixed 2", 12'hFFF, pack(1, 7, 3, 5), ref_code(pack(1, 7, 3, 5)));
  endtask

  task automatic t_ties();
    one("R8 all equal", 12'h5A5, pack(5, 5, 5, 5), 4'd0);
    one("R8 partial ties", 12'h0F0, pack(2, 7, 7, 0), 4'd9);
  endtask

  task automatic t_hold();
    logic [FULL-1:0] held;
    send(12'h123, pack(3, 2, 1, 0));
    held = out_table;
    chk("R6 held table value", held, {4'd7, 12'h123});
    for (int c = 0; c < 4; c++) begin
      in_valid = 1'b1; in_bits = 12'hDEF; in_sel = pack(0, 1, 2, 3);
      @(negedge clk);
      chk("R5 in_ready low while pending", in_ready, 0);
      chk("R6 out_valid held", out_valid, 1);
      chk("R5 table unchanged", out_table, held);
    end
    in_valid = 1'b0;
    release_out();
    chk("R7 out_valid after release", out_valid, 0);
    one("R5 next LUT after hold", 12'h456, pack(0, 1, 2, 3), 4'd0);
  endtask

  task automatic t_roundtrip();
    logic [K*SEL_W-1:0] by_code [16];
    bit have [16];
    int covered = 0;
    for (int c = 0; c < 16; c++) have[c] = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              logic [K*SEL_W-1:0] s;
              logic [NE-1:0] cd;
              s = pack(2 * a, 2 * b, 2 * c, 2 * d);
              cd = ref_code(s);
              if (!have[cd]) begin have[cd] = 1; by_code[cd] = s; covered++; end
            end
    chk("R9 codes covered", covered, 16);
    for (int t = 0; t < 20; t++) begin
      logic [FULL-1:0] tbl;
      tbl = FULL'($urandom);
      send(tbl[STORED-1:0], by_code[tbl[FULL-1:STORED]]);
      chk("R9 roundtrip table", out_table, tbl);
      release_out();
    end
  endtask

  initial begin
    t_reset();
    t_orders();
    t_ties();
    t_hold();
    t_roundtrip();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule